// File: doc/BRIEF.md
# Interrupt Expander with Presence Signature

This block gathers up to sixteen interrupt sources from an expansion board into one active-low, level-sensitive request line for a host processor. Each source passes through a synchroniser. It then sets a sticky status bit, either on a rising edge or on a high level; a per-source parameter picks which. A mask register decides which recorded sources may pull the request line low. The host reads the status word and works out the pending set as status AND NOT mask. It clears bits through a separate clear register. That register holds its value: a bit written as 1 keeps the matching status bit cleared until the host writes 0 again.

The host reaches every register over a plain 16-bit synchronous register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data comes back on the clock after the read strobe. The bus has no back-pressure: every strobe completes in one cycle, and there is no stall or ready signal. To detect the board, the host reads three constant signature words and a version word. It treats the board as absent when any signature does not match.

Top module: `irq_expander`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the status register reads 0x0000, `irq_n` is 1 and `bus_rdata` is 0x0000.
- R2: Addresses 0, 1 and 2 read 0xAAAA, 0x5555 and 0xCAFE in that order, and writes to them have no effect.
- R3: Address 3 reads the VERSION parameter (default 0x0103), and writes to it have no effect.
- R4: Address 4 reads the status word, where bit i belongs to source i. A source whose bit is set in EDGE_MASK (default 0x00FF) sets its status bit on a rising edge of its synchronised input. Any other source sets its bit while its input is high. A status bit stays set after its source falls.
- R5: Address 5 is the mask register; it can be read and written. A mask bit of 1 keeps that source from driving `irq_n`, but the source's status bit is still recorded.
- R6: Address 6 is the clear register; it can be read and written and holds its value. While a clear bit is 1, the matching status bit is forced to 0, even when a set event arrives in the same cycle.
- R7: `irq_n` is 0 on the clock after any bit of status AND NOT mask is 1, and 1 on the clock after no such bit is 1.
- R8: A read strobe returns data on `bus_rdata` on the next clock. The data reflects the register contents before that clock. In a cycle that follows no read strobe, `bus_rdata` is 0x0000.
- R9: Reads of addresses 7 to 15 return 0x0000, and writes to them have no effect.
- R10: The host start-up sequence leaves the mask at 0x001F and the status at 0x0000. The sequence is: write mask 0, write clear 0xFFFF, write clear 0, write mask 0x001F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 16 | Asynchronous interrupt sources, bit i is source i |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Combined interrupt request, active low, level |

## Verification
The bench holds a clear bit while a level source is high. A design that lets the set event win would show that status bit set. It also clears an edge source while its input stays high. A design that treats that source as level-sensitive would set the bit again at once. It records sources while they are masked, and then checks both that the status bit is set and that `irq_n` stays high. A design that gates status with the mask fails the first check; one that ignores the mask fails the second. It also writes to the signature, version and unmapped addresses. A design that decodes only some of the address bits would then return altered or aliased data.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  // Register addresses; the host software relies on these values.
  localparam int ADR_SIG0 = 0;
  localparam int ADR_SIG1 = 1;
  localparam int ADR_SIG2 = 2;
  localparam int ADR_VER  = 3;
  localparam int ADR_STAT = 4;
  localparam int ADR_MASK = 5;
  localparam int ADR_CLR  = 6;

  // Presence signature words.
  localparam logic [15:0] SIG_WORD0 = 16'hAAAA;
  localparam logic [15:0] SIG_WORD1 = 16'h5555;
  localparam logic [15:0] SIG_WORD2 = 16'hCAFE;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
  parameter int               NUM_SRC   = 16,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] set_ev;
  logic [NUM_SRC-1:0] status_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[i];
      end
      assign set_ev[i] = src_i[i] & ~prev_q;
    end else begin : g_level
      assign set_ev[i] = src_i[i];
    end
  end

  // Clear has priority over a set in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q | set_ev) & ~clr_i;
  end

  assign status_o = status_q;

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_i)) == '0));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));
endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
  import irqx_pkg::*;
#(
  parameter int                NUM_SRC = 16,
  parameter int                DATA_W  = 16,
  parameter int                ADDR_W  = 4,
  parameter logic [DATA_W-1:0] VERSION = 16'h0103
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] clr_q;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               hit_mask;
  logic               hit_clr;

  assign hit_mask = wr_i && (addr_i == ADDR_W'(ADR_MASK));
  assign hit_clr  = wr_i && (addr_i == ADDR_W'(ADR_CLR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      clr_q  <= '0;
    end else begin
      if (hit_mask) mask_q <= wdata_i[NUM_SRC-1:0];
      if (hit_clr)  clr_q  <= wdata_i[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(ADR_SIG0): rd_mux = DATA_W'(SIG_WORD0);
      ADDR_W'(ADR_SIG1): rd_mux = DATA_W'(SIG_WORD1);
      ADDR_W'(ADR_SIG2): rd_mux = DATA_W'(SIG_WORD2);
      ADDR_W'(ADR_VER):  rd_mux = VERSION;
      ADDR_W'(ADR_STAT): rd_mux = DATA_W'(status_i);
      ADDR_W'(ADR_MASK): rd_mux = DATA_W'(mask_q);
      ADDR_W'(ADR_CLR):  rd_mux = DATA_W'(clr_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
    else           rdata_q <= '0;
  end

  assign mask_o  = mask_q;
  assign clr_o   = clr_q;
  assign rdata_o = rdata_q;

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (rdata_o == '0));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mask |=> (mask_o == $past(wdata_i[NUM_SRC-1:0])));

  // R6
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_clr |=> $stable(clr_o));
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int                 NUM_SRC     = 16,
  parameter int                 DATA_W      = 16,
  parameter int                 ADDR_W      = 4,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] EDGE_MASK   = 16'h00FF,
  parameter logic [DATA_W-1:0]  VERSION     = 16'h0103
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_n
);
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] status_w;
  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] clr_w;
  logic               any_pend;
  logic               irq_n_q;

  irqx_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync)
  );

  irqx_status #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_status (
    .clk(clk), .rst_n(rst_n), .src_i(src_sync), .clr_i(clr_w),
    .status_o(status_w)
  );

  irqx_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .rd_i(bus_rd), .status_i(status_w),
    .mask_o(mask_w), .clr_o(clr_w), .rdata_o(bus_rdata)
  );

  assign any_pend = |(status_w & ~mask_w);

  // Registered so the request line is glitch-free.
  always_ff @(posedge clk) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~any_pend;
  end

  assign irq_n = irq_n_q;

  // R7
  irq_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_w & ~mask_w)) |=> !irq_n);

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_w & ~mask_w) == '0) |=> irq_n);
endmodule

// File: tb/irq_expander_bench.sv
`timescale 1ns/1ps
module irq_expander_bench;
  localparam int SYNC = 2;
  localparam logic [15:0] EDGE = 16'h00FF;
  localparam logic [15:0] VER  = 16'h0103;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        rd = 1'b0;
  logic [15:0] rdata;
  logic        irq_n;

  integer checks = 0;
  integer errors = 0;
  bit     done = 1'b0;
  bit     cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  irq_expander u_irq_expander (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq_n(irq_n)
  );

  // Behavioural reference model
  logic [15:0] m_pipe [SYNC];
  logic [15:0] m_prev, m_status, m_mask, m_clr, m_rd;
  logic        m_irq;
  string       m_tag = "R8";

  function automatic logic [15:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return 16'hAAAA;
      4'd1: return 16'h5555;
      4'd2: return 16'hCAFE;
      4'd3: return VER;
      4'd4: return m_status;
      4'd5: return m_mask;
      4'd6: return m_clr;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rtag(input logic [3:0] a);
    if (a <= 4'd2) return "R2";
    if (a == 4'd3) return "R3";
    if (a == 4'd4) return "R4";
    if (a == 4'd5) return "R5";
    if (a == 4'd6) return "R6";
    return "R9";
  endfunction

  always @(posedge clk) begin
    logic [15:0] s, setv, nrd;
    logic        nirq;
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) m_pipe[k] = '0;
      m_prev = '0; m_status = '0; m_mask = 16'hFFFF; m_clr = '0;
      m_rd = '0; m_irq = 1'b1; m_tag = "R1";
    end else begin
      s    = m_pipe[SYNC-1];
      setv = (s & ~m_prev & EDGE) | (s & ~EDGE);
      nrd  = rd ? mread(addr) : 16'h0000;
      m_tag = rd ? rtag(addr) : "R8";
      nirq = ((m_status & ~m_mask) == 16'h0000);
      m_status = (m_status | setv) & ~m_clr;
      if (wr && addr == 4'd5) m_mask = wdata;
      if (wr && addr == 4'd6) m_clr  = wdata;
      m_prev = s;
      for (int k = SYNC-1; k > 0; k--) m_pipe[k] = m_pipe[k-1];
      m_pipe[0] = src;
      m_irq = nirq;
      m_rd  = nrd;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(irq_n === m_irq, "R7", {15'd0, irq_n}, {15'd0, m_irq});
      chk(rdata === m_rd, m_tag, rdata, m_rd);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, input logic [15:0] exp, input string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1: outputs during reset
    chk(irq_n === 1'b1, "R1", {15'd0, irq_n}, 16'h0001);
    chk(rdata === 16'h0000, "R1", rdata, 16'h0000);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    bread(4'd5, 16'hFFFF, "R1");
    bread(4'd4, 16'h0000, "R1");

    // R2 signatures, R3 version, write attempts ignored
    bread(4'd0, 16'hAAAA, "R2");
    bread(4'd1, 16'h5555, "R2");
    bread(4'd2, 16'hCAFE, "R2");
    bread(4'd3, VER, "R3");
    bwrite(4'd0, 16'h1234);
    bwrite(4'd2, 16'h0000);
    bwrite(4'd3, 16'hFFFF);
    bread(4'd0, 16'hAAAA, "R2");
    bread(4'd2, 16'hCAFE, "R2");
    bread(4'd3, VER, "R3");

    // R9 unmapped space
    bwrite(4'd7, 16'hBEEF);
    bwrite(4'd15, 16'hBEEF);
    bread(4'd7, 16'h0000, "R9");
    bread(4'd15, 16'h0000, "R9");
    bread(4'd5, 16'hFFFF, "R9");

    // R10 start-up sequence
    bwrite(4'd5, 16'h0000);
    bwrite(4'd6, 16'hFFFF);
    bwrite(4'd6, 16'h0000);
    bwrite(4'd5, 16'h001F);
    bread(4'd5, 16'h001F, "R10");
    bread(4'd4, 16'h0000, "R10");

    // R4/R5: one-cycle pulse on masked edge source 0 is recorded
    src[0] = 1'b1; cyc(1); src[0] = 1'b0;
    cyc(6);
    bread(4'd4, 16'h0001, "R4");
    chk(irq_n === 1'b1, "R5", {15'd0, irq_n}, 16'h0001);

    // R7: unmasked edge source 5 held high
    src[5] = 1'b1;
    cyc(6);
    bread(4'd4, 16'h0021, "R4");
    chk(irq_n === 1'b0, "R7", {15'd0, irq_n}, 16'h0000);

    // R6 clear, then R4 edge source held high does not set again
    bwrite(4'd6, 16'h0021);
    cyc(3);
    bread(4'd4, 16'h0000, "R6");
    bwrite(4'd6, 16'h0000);
    cyc(4);
    bread(4'd4, 16'h0000, "R4");
    chk(irq_n === 1'b1, "R7", {15'd0, irq_n}, 16'h0001);

    // R6: held clear beats a level source that is high
    bwrite(4'd6, 16'h0200);
    src[9] = 1'b1;
    cyc(6);
    bread(4'd4, 16'h0000, "R6");
    bread(4'd6, 16'h0200, "R6");
    bwrite(4'd6, 16'h0000);
    cyc(4);
    bread(4'd4, 16'h0200, "R4");
    chk(irq_n === 1'b0, "R7", {15'd0, irq_n}, 16'h0000);
    bwrite(4'd5, 16'hFFFF);
    cyc(1);
    chk(irq_n === 1'b1, "R5", {15'd0, irq_n}, 16'h0001);
    bread(4'd4, 16'h0200, "R5");

    // Clean up
    src = '0;
    bwrite(4'd6, 16'hFFFF);
    bwrite(4'd6, 16'h0000);
    cyc(4);

    // Random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int op;
      if (($urandom % 4) == 0) src = 16'($urandom);
      op = int'($urandom % 10);
      if (op == 0) bwrite(4'd5, 16'($urandom));
      else if (op == 1) bwrite(4'd6, (($urandom % 3) == 0) ? 16'($urandom) : 16'h0000);
      else if (op == 2) bwrite(4'($urandom), 16'($urandom));
      else if (op <= 5) begin
        addr = 4'($urandom); rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end else cyc(1);
    end

    cyc(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule